// File: doc/BRIEF.md
# Vector element step controller

This block keeps the state of one explicit element-at-a-time vector loop. The state is a vector length, a maximum vector length, a source element index and a destination element index. A decoded set-length command loads both lengths. A flag in the same command chooses whether the loop runs in vertical-first mode, which is one mode bit inside a 64-bit status word. The command also returns the new length as a value that the surrounding pipeline can write to a general register.

A decoded step command moves both element indices forward by one. When the next index would reach the vector length, the block ends the loop itself. It returns both indices to zero, drops the mode bit and, if the step asked for a record, sets the equal flag of a 4-bit condition field. A following conditional branch tests that flag to leave the loop. Commands arrive as single-cycle strobes with their operands. Every result is registered and can be seen on the outputs after the clock edge that accepts the command.

Top module: `vstep_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the lengths, both indices, the mode bit, the condition field and `result_valid` to zero.
- R2: A set-length command loads `vl` and `mvl` from its operands. It loads the mode bit from `setlen_vf`, and leaves both indices unchanged. The mode bit appears as bit 57 of `status_word` (LSB-0), and every other bit of `status_word` is zero.
- R3: After a set-length command, `result_valid` is high for exactly one cycle and `result` holds the new vector length, zero-extended to 64 bits (a length of 2 gives 2).
- R4: A step whose incremented index is still below `vl` adds one to both `src_idx` and `dst_idx` and leaves the mode bit unchanged.
- R5: A step whose incremented index reaches or passes `vl` sets both indices to zero and clears the mode bit.
- R6: The condition field is laid out as `cond[3]`=less-than, `cond[2]`=greater-than, `cond[1]`=equal, `cond[0]`=summary-overflow. A recorded step writes equal as 1 when it wraps and as 0 when it does not, and always writes the other three bits as 0.
- R7: A step with `step_rec` low leaves `cond` at its previous value. Set-length never changes `cond`.
- R8: A step while `vl` is zero wraps at once: both indices stay zero, the mode bit clears, and a recorded step sets equal to 1.
- R9: When set-length and step arrive in the same cycle, only the set-length takes effect. The indices and `cond` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| setlen_valid | input | 1 | Set-length command strobe |
| setlen_vl | input | 7 | New vector length |
| setlen_mvl | input | 7 | New maximum vector length |
| setlen_vf | input | 1 | Value for the vertical-first mode bit |
| step_valid | input | 1 | Step command strobe |
| step_rec | input | 1 | Step writes the condition field |
| vl | output | 7 | Current vector length |
| mvl | output | 7 | Current maximum vector length |
| src_idx | output | 7 | Source element index |
| dst_idx | output | 7 | Destination element index |
| vf_mode | output | 1 | Vertical-first mode bit |
| status_word | output | 64 | Status word carrying the mode bit at bit 57 |
| cond | output | 4 | Condition field {lt, gt, eq, so} |
| result | output | 64 | Value for the destination register |
| result_valid | output | 1 | `result` holds a set-length return value |

## Verification
The hardest cases to reach are the step that lands exactly on the vector length at the top of the 7-bit range (127), and the step taken with a zero length. Both need the length set first and then the right number of steps before the wrap. The bench therefore sweeps every length from 0 to 127. For each length it runs a full loop of length-plus-one steps and checks the indices, the mode bit and the equal flag after every step. It also drives a set-length and a step in the same cycle in the middle of a loop, and runs steps without the record flag, to show that the condition field and the indices are left alone.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  function automatic cond_t step_cond(input logic done);
    cond_t c;
    c.lt = 1'b0;
    c.gt = 1'b0;
    c.eq = done;
    c.so = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/vstep_walker.sv
module vstep_walker #(
  parameter int IDX_W = 7,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_go,
  input  logic [LEN_W-1:0] vl,
  output logic [IDX_W-1:0] src_idx,
  output logic [IDX_W-1:0] dst_idx,
  output logic             done
);
  localparam int CW = ((IDX_W > LEN_W) ? IDX_W : LEN_W) + 1;
  localparam int LANES = 2;

  logic [IDX_W-1:0] lane_q [LANES];
  logic [CW-1:0]    next_idx;

  // Completion is judged on the source lane; both lanes always move together.
  assign next_idx = CW'(lane_q[0]) + CW'(1);
  assign done     = (next_idx >= CW'(vl));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        lane_q[g] <= '0;
      else if (step_go)
        lane_q[g] <= done ? '0 : lane_q[g] + IDX_W'(1);
    end
  end

  assign src_idx = lane_q[0];
  assign dst_idx = lane_q[1];
endmodule

// File: rtl/vstep_len_reg.sv
module vstep_len_reg #(
  parameter int LEN_W = 7,
  parameter int RES_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             setlen_valid,
  input  logic [LEN_W-1:0] setlen_vl,
  input  logic [LEN_W-1:0] setlen_mvl,
  input  logic             setlen_vf,
  input  logic             wrap,
  output logic [LEN_W-1:0] vl,
  output logic [LEN_W-1:0] mvl,
  output logic             vf_mode,
  output logic [RES_W-1:0] result,
  output logic             result_valid
);
  logic [LEN_W-1:0] vl_q, mvl_q;
  logic             vf_q, rv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q  <= '0;
      mvl_q <= '0;
      vf_q  <= 1'b0;
      rv_q  <= 1'b0;
    end else if (setlen_valid) begin
      vl_q  <= setlen_vl;
      mvl_q <= setlen_mvl;
      vf_q  <= setlen_vf;
      rv_q  <= 1'b1;
    end else begin
      rv_q <= 1'b0;
      if (wrap) vf_q <= 1'b0;
    end
  end

  assign vl           = vl_q;
  assign mvl          = mvl_q;
  assign vf_mode      = vf_q;
  assign result       = RES_W'(vl_q);
  assign result_valid = rv_q;
endmodule

// File: rtl/vstep_cond_reg.sv
module vstep_cond_reg
  import vstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cond_we,
  input  logic       done,
  output logic [3:0] cond
);
  cond_t cond_q;

  always_ff @(posedge clk) begin
    if (rst)          cond_q <= '0;
    else if (cond_we) cond_q <= step_cond(done);
  end

  assign cond = cond_q;
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl #(
  parameter int LEN_W    = 7,
  parameter int IDX_W    = 7,
  parameter int STATUS_W = 64,
  parameter int VF_BIT   = 57,
  parameter int RES_W    = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                setlen_valid,
  input  logic [LEN_W-1:0]    setlen_vl,
  input  logic [LEN_W-1:0]    setlen_mvl,
  input  logic                setlen_vf,
  input  logic                step_valid,
  input  logic                step_rec,
  output logic [LEN_W-1:0]    vl,
  output logic [LEN_W-1:0]    mvl,
  output logic [IDX_W-1:0]    src_idx,
  output logic [IDX_W-1:0]    dst_idx,
  output logic                vf_mode,
  output logic [STATUS_W-1:0] status_word,
  output logic [3:0]          cond,
  output logic [RES_W-1:0]    result,
  output logic                result_valid
);
  logic step_go, done, wrap;

  // Set-length takes priority over a step in the same cycle.
  assign step_go = step_valid & ~setlen_valid;
  assign wrap    = step_go & done;

  vstep_walker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) i_walker (
    .clk(clk), .rst(rst), .step_go(step_go), .vl(vl),
    .src_idx(src_idx), .dst_idx(dst_idx), .done(done)
  );

  vstep_len_reg #(.LEN_W(LEN_W), .RES_W(RES_W)) i_len (
    .clk(clk), .rst(rst), .setlen_valid(setlen_valid),
    .setlen_vl(setlen_vl), .setlen_mvl(setlen_mvl), .setlen_vf(setlen_vf),
    .wrap(wrap), .vl(vl), .mvl(mvl), .vf_mode(vf_mode),
    .result(result), .result_valid(result_valid)
  );

  vstep_cond_reg i_cond (
    .clk(clk), .rst(rst), .cond_we(step_go & step_rec), .done(done),
    .cond(cond)
  );

  always_comb begin
    status_word         = '0;
    status_word[VF_BIT] = vf_mode;
  end
endmodule

// File: rtl/vstep_ctrl_chk.sv
module vstep_ctrl_chk #(
  parameter int LEN_W = 7,
  parameter int IDX_W = 7,
  parameter int RES_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             setlen_valid,
  input logic [LEN_W-1:0] setlen_vl,
  input logic             step_valid,
  input logic             step_rec,
  input logic [LEN_W-1:0] vl,
  input logic [IDX_W-1:0] src_idx,
  input logic [IDX_W-1:0] dst_idx,
  input logic             vf_mode,
  input logic [3:0]       cond,
  input logic [RES_W-1:0] result,
  input logic             result_valid
);
  localparam int CW = ((IDX_W > LEN_W) ? IDX_W : LEN_W) + 1;

  logic [CW-1:0] nx;
  assign nx = CW'(src_idx) + CW'(1);

  a_r4_step_increments: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !setlen_valid && nx < CW'(vl)) |=>
      (src_idx == $past(src_idx) + IDX_W'(1) && dst_idx == $past(dst_idx) + IDX_W'(1)
       && vf_mode == $past(vf_mode)));

  a_r5_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !setlen_valid && nx >= CW'(vl)) |=>
      (src_idx == '0 && dst_idx == '0 && !vf_mode));

  a_r6_eq_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (step_valid && step_rec && !setlen_valid) |=>
      (cond[1] == ($past(nx) >= CW'($past(vl)))));

  a_r6_other_flags_zero: assert property (@(posedge clk) disable iff (rst)
    (cond[3] == 1'b0 && cond[2] == 1'b0 && cond[0] == 1'b0));

  a_r7_cond_holds: assert property (@(posedge clk) disable iff (rst)
    !(step_valid && step_rec && !setlen_valid) |=> $stable(cond));

  a_r9_setlen_wins: assert property (@(posedge clk) disable iff (rst)
    setlen_valid |=> ($stable(src_idx) && $stable(dst_idx)));

  a_r3_result_returned: assert property (@(posedge clk) disable iff (rst)
    setlen_valid |=> (result_valid && result == RES_W'($past(setlen_vl))));
endmodule

bind vstep_ctrl vstep_ctrl_chk #(.LEN_W(LEN_W), .IDX_W(IDX_W), .RES_W(RES_W)) i_chk (
  .clk(clk), .rst(rst), .setlen_valid(setlen_valid), .setlen_vl(setlen_vl),
  .step_valid(step_valid), .step_rec(step_rec), .vl(vl), .src_idx(src_idx),
  .dst_idx(dst_idx), .vf_mode(vf_mode), .cond(cond), .result(result),
  .result_valid(result_valid)
);

// File: tb/test_vstep_ctrl.sv
module test_vstep_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setlen_valid = 1'b0;
  logic [6:0]  setlen_vl = '0, setlen_mvl = '0;
  logic        setlen_vf = 1'b0;
  logic        step_valid = 1'b0, step_rec = 1'b0;
  logic [6:0]  vl, mvl, src_idx, dst_idx;
  logic        vf_mode, result_valid;
  logic [63:0] status_word, result;
  logic [3:0]  cond;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  int         m_vl = 0, m_mvl = 0, m_idx = 0;
  logic       m_vf = 1'b0;
  logic [3:0] m_cond = 4'b0000;

  always #5 clk = ~clk;

  vstep_ctrl i_vstep_ctrl (
    .clk(clk), .rst(rst), .setlen_valid(setlen_valid), .setlen_vl(setlen_vl),
    .setlen_mvl(setlen_mvl), .setlen_vf(setlen_vf), .step_valid(step_valid),
    .step_rec(step_rec), .vl(vl), .mvl(mvl), .src_idx(src_idx), .dst_idx(dst_idx),
    .vf_mode(vf_mode), .status_word(status_word), .cond(cond), .result(result),
    .result_valid(result_valid)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input string ctag, input logic rv);
    chk(tag, "vl", 64'(vl), 64'(m_vl));
    chk(tag, "mvl", 64'(mvl), 64'(m_mvl));
    chk(tag, "src_idx", 64'(src_idx), 64'(m_idx));
    chk(tag, "dst_idx", 64'(dst_idx), 64'(m_idx));
    chk(tag, "vf_mode", 64'(vf_mode), 64'(m_vf));
    chk("R2", "status_word", status_word, 64'(m_vf) << 57);
    chk(ctag, "cond", 64'(cond), 64'(m_cond));
    chk("R3", "result_valid", 64'(result_valid), 64'(rv));
    if (rv) chk("R3", "result", result, 64'(m_vl));
  endtask

  // Drive one command for one cycle, then check after the accepting edge.
  task automatic cmd(input logic sl, input int nvl, input int nmvl, input logic f,
                     input logic st, input logic rec);
    string tag, ctag;
    tag = "R2"; ctag = "R7";
    if (sl) begin
      m_vl = nvl; m_mvl = nmvl; m_vf = f;
      if (st) begin tag = "R9"; ctag = "R9"; end
    end else if (st) begin
      if (m_idx + 1 >= m_vl) begin
        m_idx = 0; m_vf = 1'b0;
        tag = (m_vl == 0) ? "R8" : "R5";
        if (rec) m_cond = 4'b0010;
      end else begin
        m_idx = m_idx + 1;
        tag = "R4";
        if (rec) m_cond = 4'b0000;
      end
      ctag = rec ? ((m_vl == 0) ? "R8" : "R6") : "R7";
    end
    @(negedge clk);
    setlen_valid = sl; setlen_vl = 7'(nvl); setlen_mvl = 7'(nmvl); setlen_vf = f;
    step_valid = st; step_rec = rec;
    @(negedge clk);
    setlen_valid = 1'b0; step_valid = 1'b0; step_rec = 1'b0;
    chk_state(tag, ctag, sl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_state("R1", "R1", 1'b0);

    // Full sweep of lengths, with a full loop per length.
    for (int n = 0; n < 128; n++) begin
      cmd(1'b1, n, (n + 3) % 128, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k <= n; k++) cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);
    end

    // Set-length with the mode flag low, then unrecorded steps.
    cmd(1'b1, 4, 9, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'b0);

    // Alternate record flag through a loop of 6.
    cmd(1'b1, 6, 6, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 14; k++) cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'(k % 2));

    // Collision mid-loop: set-length wins and indices hold.
    cmd(1'b1, 5, 5, 1'b1, 1'b0, 1'b0);
    cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);
    cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);
    cmd(1'b1, 3, 7, 1'b1, 1'b1, 1'b1);
    cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);

    // Zero length step while in mode.
    cmd(1'b1, 0, 0, 1'b1, 1'b0, 1'b0);
    cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);

    // Shrink length below current index: next step wraps.
    cmd(1'b1, 10, 10, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);
    cmd(1'b1, 2, 10, 1'b1, 1'b0, 1'b0);
    cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);

    // Reset mid-run returns everything to zero.
    cmd(1'b1, 8, 8, 1'b1, 1'b0, 1'b0);
    cmd(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_vl = 0; m_mvl = 0; m_idx = 0; m_vf = 1'b0; m_cond = 4'b0000;
    chk_state("R1", "R1", 1'b0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule